// File: doc/BRIEF.md
# AMI Receive Clock Recovery Divider

This block takes the two sliced rails of a bipolar return-to-zero line, one rail for positive marks and one for negative marks, and turns them into a recovered bit clock with retimed data. All logic runs on an oversampling clock that is 8 or 16 times the line rate. A divide counter free-runs and produces a square-wave receive clock. Every positive mark that is detected restarts the counter, so the clock phase follows the line. Both rails are gathered over one bit period and presented on the data outputs. The outputs change only on the rising edge of the recovered clock, so downstream logic can sample them on the falling edge with half a bit period of margin on each side.

When the mode input is low, clock recovery is switched off. The recovered clock is held low, and each rail output becomes a stretched copy of its input: every detected mark produces a pulse of fixed length on the output.

Both rail inputs are treated as asynchronous. Each passes through a two-stage synchronizer and a rising-edge detector before any other logic sees it.

Top module: `ami_clk_recover`

## Requirements
- R1: A clock edge with `rst_n` low clears the divider, the capture state, the data outputs and the stretch timers, so `rclk`, `dout_p` and `dout_n` read 0 during reset and on the first cycle after it.
- R2: In recovery mode (`mode_rec` = 1) with no marks arriving, `rclk` has a period of N oversampling cycles, where N = 8 for `ratio_sel` = 0 and N = 16 for `ratio_sel` = 1. It is high for N/2 cycles and low for N/2 cycles.
- R3: A rail input that is first sampled high at clock edge k is detected at edge k+2. In recovery mode, a positive-rail detection restarts the divider at that edge. `rclk` is then low for N/2 cycles before it rises again.
- R4: If a positive detection falls inside the high half of `rclk`, that high phase ends at the detection edge. The high phase is therefore shorter than N/2 cycles.
- R5: Negative-rail detections never move the divider phase. The `rclk` high and low times stay at N/2 cycles each.
- R6: In recovery mode, `dout_p` and `dout_n` change only at the edge where `rclk` rises. Each output shows whether its rail had a detection during the bit period that ended at that edge, so the value is stable at the next falling edge of `rclk`.
- R7: A detection at the very edge where `rclk` rises is reported in the data presented at that edge, and is not carried into the next bit period. A detection one cycle later belongs to the next bit period.
- R8: With `mode_rec` = 0, `rclk` stays low from the cycle after the mode drops.
- R9: With `mode_rec` = 0, a rail detection drives that rail's output high for exactly STRETCH_CYC cycles, starting on the cycle after the detection edge. The other rail's output is unaffected.
- R10: With `mode_rec` = 0, a new detection during an active stretch restarts the full STRETCH_CYC count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock (8x or 16x line rate) |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_rec | input | 1 | 1 = clock recovery, 0 = bypass with pulse stretching |
| ratio_sel | input | 1 | Oversampling ratio: 0 = divide by DIV_SLOW, 1 = divide by DIV_FAST |
| rail_p | input | 1 | Positive-mark comparator output, asynchronous |
| rail_n | input | 1 | Negative-mark comparator output, asynchronous |
| rclk | output | 1 | Recovered bit clock |
| dout_p | output | 1 | Retimed (or stretched) positive data |
| dout_n | output | 1 | Retimed (or stretched) negative data |

## Verification
The two functions that can land on the same oversampling edge are a rail detection and the handover of captured data at the rising edge of `rclk`. The bench first locks the phase with a positive mark. It then drives a negative mark timed so that its detection lands exactly on the handover edge, and in a separate slot lands one cycle after it. A scoreboard holds the expected data for each bit period and compares it with the outputs at every falling edge of `rclk`. The on-edge mark must appear in the current bit period and be absent from the next one. The late mark must appear only in the next bit period. A second coincidence, a positive mark arriving while `rclk` is high, is provoked at a known offset and judged by the measured widths of the high and low phases.

// File: rtl/ami_pkg.sv
// Package: shared constants and helpers for the AMI clock recovery block.
// Assumes rails are carried as a 2-bit vector, positive rail in the upper bit.
package ami_pkg;
    localparam int RAIL_CNT = 2;
    localparam int IDX_P    = 1;
    localparam int IDX_N    = 0;

    typedef logic [RAIL_CNT-1:0] rail_vec_t;

    // Half of a division ratio; ratios are assumed even.
    function automatic int half_of(input int ratio);
        return ratio / 2;
    endfunction

    // Larger of two ratios, used to size the divide counter.
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/ami_edge_sync.sv
// Module: brings one asynchronous rail into the clock domain and flags its rising edge.
// Assumes: STAGES >= 2; rise_o is high for one cycle per low-to-high rail change.
module ami_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_i,
    output logic rise_o
);
    logic [STAGES:0] shift_q;

    // Synchronizer chain plus one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[STAGES-1:0], rail_i};
    end

    assign rise_o = shift_q[STAGES-1] & ~shift_q[STAGES];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o); // R3
endmodule

// File: rtl/ami_phase_div.sv
// Module: free-running divide counter that produces the recovered clock.
// A realign request restarts the count at zero (clock low half). xfer_o marks
// the edge at which the clock rises, i.e. the data handover point.
// Assumes: DIV_A and DIV_B are even, >= 4; en_i low holds the counter at zero.
module ami_phase_div
    import ami_pkg::*;
#(
    parameter int DIV_A = 8,
    parameter int DIV_B = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic sel_i,
    input  logic realign_i,
    output logic rclk_o,
    output logic xfer_o
);
    localparam int CNT_W  = $clog2(max_of(DIV_A, DIV_B));
    localparam int HALF_A = half_of(DIV_A);
    localparam int HALF_B = half_of(DIV_B);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] half_cnt;

    // Pick terminal count and half point from the ratio select.
    always_comb begin
        last_cnt = sel_i ? CNT_W'(DIV_B - 1) : CNT_W'(DIV_A - 1);
        half_cnt = sel_i ? CNT_W'(HALF_B)    : CNT_W'(HALF_A);
    end

    // Counter: cleared by reset, bypass or realign, else wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)        cnt_q <= '0;
        else if (realign_i)         cnt_q <= '0;
        else if (cnt_q >= last_cnt) cnt_q <= '0;
        else                        cnt_q <= cnt_q + CNT_W'(1);
    end

    assign rclk_o = (cnt_q >= half_cnt);
    assign xfer_o = en_i && !realign_i && (cnt_q == half_cnt - CNT_W'(1));

    AST_REALIGN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        realign_i |=> !rclk_o); // R3
endmodule

// File: rtl/ami_retime.sv
// Module: gathers rail detections over one bit period and hands them to the
// outputs at the rising edge of the recovered clock.
// Assumes xfer_i pulses once per bit period and only while en_i is high.
module ami_retime
    import ami_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      xfer_i,
    input  rail_vec_t rise_i,
    output rail_vec_t dout_o
);
    rail_vec_t cap_q;

    // Capture sticky flags; on handover, present them including a same-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= '0;
            dout_o <= '0;
        end else if (!en_i) begin
            cap_q  <= '0;
        end else if (xfer_i) begin
            dout_o <= cap_q | rise_i;
            cap_q  <= '0;
        end else begin
            cap_q  <= cap_q | rise_i;
        end
    end

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_i |=> $stable(dout_o)); // R6
    AST_EDGE_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && rise_i[IDX_N]) |=> dout_o[IDX_N]); // R7
endmodule

// File: rtl/ami_stretch.sv
// Module: bypass-mode pulse stretcher for one rail.
// Each detection (re)loads a down-counter with LEN; output is high while nonzero.
// Assumes LEN >= 1; en_i low clears the timer.
module ami_stretch #(
    parameter int LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic rise_i,
    output logic out_o
);
    localparam int TMR_W = $clog2(LEN + 1);

    logic [TMR_W-1:0] tmr_q;

    // Load on detection, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i)     tmr_q <= '0;
        else if (rise_i)         tmr_q <= TMR_W'(LEN);
        else if (tmr_q != '0)    tmr_q <= tmr_q - TMR_W'(1);
    end

    assign out_o = (tmr_q != '0);

    AST_STRETCH_START: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && rise_i) |=> out_o); // R9
endmodule

// File: rtl/ami_clk_recover.sv
// Module: top of the AMI receive clock recovery block.
// Synchronizes both rails, runs the phase divider (realigned by positive marks),
// retimes data to the recovered clock, or in bypass mode stretches the marks.
// Assumes ratio_sel changes only while in reset or in bypass.
module ami_clk_recover
    import ami_pkg::*;
#(
    parameter int DIV_SLOW    = 8,
    parameter int DIV_FAST    = 16,
    parameter int STRETCH_CYC = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_rec,
    input  logic ratio_sel,
    input  logic rail_p,
    input  logic rail_n,
    output logic rclk,
    output logic dout_p,
    output logic dout_n
);
    rail_vec_t rail_in;
    rail_vec_t rise;
    rail_vec_t ret_q;
    rail_vec_t str_q;
    logic      xfer;
    logic      realign;

    assign rail_in[IDX_P] = rail_p;
    assign rail_in[IDX_N] = rail_n;

    // One synchronizer and one stretcher per rail.
    for (genvar g = 0; g < RAIL_CNT; g++) begin : g_rail
        ami_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .rail_i (rail_in[g]),
            .rise_o (rise[g])
        );
        ami_stretch #(.LEN(STRETCH_CYC)) u_str (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (!mode_rec),
            .rise_i (rise[g]),
            .out_o  (str_q[g])
        );
    end

    // Only positive marks steer the divider phase.
    assign realign = mode_rec && rise[IDX_P];

    ami_phase_div #(.DIV_A(DIV_SLOW), .DIV_B(DIV_FAST)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (mode_rec),
        .sel_i     (ratio_sel),
        .realign_i (realign),
        .rclk_o    (rclk),
        .xfer_o    (xfer)
    );

    ami_retime u_ret (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (mode_rec),
        .xfer_i (xfer),
        .rise_i (rise),
        .dout_o (ret_q)
    );

    assign dout_p = mode_rec ? ret_q[IDX_P] : str_q[IDX_P];
    assign dout_n = mode_rec ? ret_q[IDX_N] : str_q[IDX_N];

    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_rec |=> !rclk); // R8
endmodule

// File: tb/ami_clk_recover_bench.sv
`timescale 1ns/1ps
module ami_clk_recover_bench;
    localparam int S = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_rec = 1'b1;
    logic ratio_sel = 1'b0;
    logic rail_p = 1'b0;
    logic rail_n = 1'b0;
    logic rclk, dout_p, dout_n;

    int checks = 0;
    int failures = 0;
    int N = 8;
    int H = 4;
    bit carry_n = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];
    logic [1:0] mon_e;
    string      mon_t;
    logic       prev_rclk = 1'b0;

    always #2 clk = ~clk;

    ami_clk_recover #(.STRETCH_CYC(S)) u_ami_clk_recover (
        .clk(clk), .rst_n(rst_n), .mode_rec(mode_rec), .ratio_sel(ratio_sel),
        .rail_p(rail_p), .rail_n(rail_n), .rclk(rclk), .dout_p(dout_p), .dout_n(dout_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: at each falling edge of rclk, pop and compare one expected bit period.
    always @(posedge clk) begin
        #1;
        if (!rst_n) prev_rclk = 1'b0;
        else begin
            if (prev_rclk && !rclk && exp_q.size() > 0) begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                chk({dout_p, dout_n} == mon_e, mon_t, {dout_p, dout_n}, mon_e);
            end
            prev_rclk = rclk;
        end
    end

    task automatic do_reset(input bit ratio);
        @(negedge clk);
        rst_n = 1'b0; ratio_sel = ratio; mode_rec = 1'b1;
        rail_p = 1'b0; rail_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({rclk, dout_p, dout_n} == 3'b000, "R1 in reset", {rclk, dout_p, dout_n}, 0);
        rst_n = 1'b1;
        N = ratio ? 16 : 8;
        H = N / 2;
        carry_n = 1'b0;
        @(negedge clk);
        chk({rclk, dout_p, dout_n} == 3'b000, "R1 after release", {rclk, dout_p, dout_n}, 0);
    endtask

    // Driver: one symbol per bit slot (+1, -1 or 0), optional extra negative mark
    // late cycles after the half point (-1 = none). Pushes the expected data.
    task automatic send(input int sym, input int late);
        logic [1:0] e;
        string t;
        e = {sym == 1, (sym == -1) || carry_n};
        t = carry_n ? "R7 late mark" : "R6 retimed data";
        carry_n = 1'b0;
        if (late == 0) begin e[0] = 1'b1; t = "R7 on-edge mark"; end
        if (late == 1) carry_n = 1'b1;
        rail_p = (sym == 1);
        rail_n = (sym == -1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        repeat (H - 3) @(negedge clk);
        rail_p = 1'b0; rail_n = 1'b0;
        if (late >= 0) begin
            repeat (late) @(negedge clk);
            rail_n = 1'b1;
            repeat (2) @(negedge clk);
            rail_n = 1'b0;
            repeat (N - H - late - 2) @(negedge clk);
        end else begin
            repeat (N - H) @(negedge clk);
        end
    endtask

    task automatic measure(output int hi, output int lo);
        hi = 0; lo = 0;
        while (rclk)  @(negedge clk);
        while (!rclk) @(negedge clk);
        while (rclk)  begin hi++; @(negedge clk); end
        while (!rclk) begin lo++; @(negedge clk); end
    endtask

    task automatic drain();
        repeat (N + 4) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all periods seen", exp_q.size(), 0);
    endtask

    task automatic bp_run(input bit use_n, input bit retrig,
                          output int first, output int on_cnt, output int oth_cnt, output int clk_cnt);
        logic on, oth;
        first = -1; on_cnt = 0; oth_cnt = 0; clk_cnt = 0;
        @(negedge clk);
        if (use_n) rail_n = 1'b1; else rail_p = 1'b1;
        for (int i = 0; i < S + 12; i++) begin
            @(negedge clk);
            on  = use_n ? dout_n : dout_p;
            oth = use_n ? dout_p : dout_n;
            if (on) begin on_cnt++; if (first < 0) first = i; end
            if (oth)  oth_cnt++;
            if (rclk) clk_cnt++;
            if (i == 0 || (retrig && i == 3)) begin rail_p = 1'b0; rail_n = 1'b0; end
            if (retrig && i == 2) begin if (use_n) rail_n = 1'b1; else rail_p = 1'b1; end
        end
    endtask

    initial begin
        int hi, lo, first, on_c, oth_c, clk_c;

        // 8x ratio: reset and free run
        do_reset(1'b0);
        for (int k = 0; k < 2; k++) begin
            measure(hi, lo);
            chk(hi == H, "R2 free-run high 8x", hi, H);
            chk(lo == H, "R2 free-run low 8x", lo, H);
        end

        // Scoreboard sequence with edge collisions
        @(negedge clk);
        send(1, -1); send(0, -1); send(-1, -1); send(1, 0); send(0, -1);
        send(1, 1);  send(0, -1); send(-1, -1); send(1, -1); send(0, -1);
        drain();

        // Positive mark inside the high phase cuts it short (R4), then low half (R3)
        @(negedge clk);
        send(1, -1);
        fork
            measure(hi, lo);
            begin
                repeat (H + 2) @(negedge clk);
                rail_p = 1'b1;
                repeat (H) @(negedge clk);
                rail_p = 1'b0;
            end
        join
        chk(hi == 2, "R4 shortened high", hi, 2);
        chk(lo == H, "R3 low half after realign", lo, H);
        drain();

        // Negative mark at the same offset leaves the phase alone (R5)
        @(negedge clk);
        send(1, -1);
        fork
            measure(hi, lo);
            begin
                repeat (H + 2) @(negedge clk);
                rail_n = 1'b1;
                repeat (H) @(negedge clk);
                rail_n = 1'b0;
            end
        join
        chk(hi == H, "R5 high unchanged", hi, H);
        chk(lo == H, "R5 low unchanged", lo, H);
        drain();

        // Reset in mid-run clears a high output (R1)
        @(negedge clk);
        send(1, -1);
        chk(dout_p == 1'b1, "R6 data before reset", dout_p, 1);
        exp_q.delete(); tag_q.delete();
        do_reset(1'b0);

        // Bypass mode
        @(negedge clk);
        mode_rec = 1'b0;
        repeat (4) @(negedge clk);
        chk(rclk == 1'b0, "R8 clock held low", rclk, 0);
        bp_run(1'b0, 1'b0, first, on_c, oth_c, clk_c);
        chk(first == 2, "R9 stretch start p", first, 2);
        chk(on_c == S, "R9 stretch length p", on_c, S);
        chk(oth_c == 0, "R9 other rail idle", oth_c, 0);
        chk(clk_c == 0, "R8 no clock in bypass", clk_c, 0);
        bp_run(1'b1, 1'b0, first, on_c, oth_c, clk_c);
        chk(on_c == S, "R9 stretch length n", on_c, S);
        chk(oth_c == 0, "R9 p idle during n", oth_c, 0);
        bp_run(1'b0, 1'b1, first, on_c, oth_c, clk_c);
        chk(first == 2, "R10 retrigger start", first, 2);
        chk(on_c == S + 3, "R10 retrigger length", on_c, S + 3);

        // 16x ratio
        do_reset(1'b1);
        measure(hi, lo);
        chk(hi == H, "R2 free-run high 16x", hi, H);
        chk(lo == H, "R2 free-run low 16x", lo, H);
        @(negedge clk);
        send(1, -1); send(-1, -1); send(1, 0); send(0, -1);
        send(-1, -1); send(1, 1); send(0, -1); send(1, -1);
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule